// File: doc/BRIEF.md
# Gated Frequency and Period Counter

This block measures one of two external digital inputs. It can report the number of rising edges that occur during a timed gate, which gives frequency. It can also report the number of reference clock cycles that span one or two input periods, which gives period. A two-bit source code picks both the input and the mode. A two-bit gate code sets the gate length. A bias-keep bit controls the input pull-down request. A start bit runs or clears the counter. The gate is timed by a free-running one-cycle millisecond tick, and period counting uses the block clock as its reference.

When start rises, the block latches its configuration and counts a settling wait in whole ticks. It then runs the gate. When the gate ends, it raises a done flag and freezes the count. Both outputs hold until start falls, and that clears them. The result is a held level rather than a stream, so there is no valid/ready handshake and no back-pressure. The consumer reads `count_o` at any time while `done_o` is high.

Top module: `gcnt_top`

## Requirements
- R1: While start is 0, the block is idle, the count reads 0 and done reads 0. A count in progress is discarded one cycle after start falls.
- R2: The source code works as follows. With bit 1 set, the block measures the frequency of the high-speed input. With code 01, it measures the frequency of the low-speed input. With code 00, it measures the period of the low-speed input.
- R3: In frequency mode, the count is the number of rising edges of the selected input, after a two-flop synchroniser, during a gate of 4, 8, 32 or 64 ticks for gate codes 00, 01, 10 and 11.
- R4: In period mode, the count is the number of clock cycles from one synchronised rising edge of the low-speed input to the next one (gate code 00 or 01) or to the second one after it (gate code 10 or 11).
- R5: Before the gate, the block waits 4 ticks for gate codes 00/01 or 8 ticks for gate codes 10/11 when bias-keep is 0, and 2 ticks when bias-keep is 1. The start may fall anywhere within the first tick period.
- R6: The pull-down request is 1 only while the block is idle with bias-keep at 0. It is 0 whenever bias-keep is 1 and throughout a measurement.
- R7: When the gate ends, done becomes 1 and the count stays fixed until start returns to 0.
- R8: The count saturates at its all-ones value (2^COUNT_W - 1) and does not wrap.
- R9: The source code, gate code and bias-keep are sampled when start rises. Changing them during a measurement does not alter the result.
- R10: The input that is not selected has no effect on the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock and period reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick_i | input | 1 | One-cycle pulse, once per millisecond |
| start_i | input | 1 | 1 runs a measurement, 0 holds the block cleared |
| src_mode_i | input | 2 | Source and mode code (R2) |
| gate_sel_i | input | 2 | Gate length or period count code |
| bias_keep_i | input | 1 | 1 shortens the wait and suppresses the pull-down request |
| hi_in_i | input | 1 | High-speed measured input (asynchronous) |
| lo_in_i | input | 1 | Low-speed measured input (asynchronous) |
| count_o | output | COUNT_W | Measured count |
| done_o | output | 1 | Measurement complete, result frozen |
| pulldown_en_o | output | 1 | Request to pull the measured inputs low |

## Verification
The hardest condition to reach from the ports is saturation. At 20 bits it would need about a million reference cycles in one period. A second instance with an 8-bit count therefore measures a 400-cycle period alongside the full-width instance, so the same stimulus checks both the clamped and the exact result. The bench also scrambles every configuration input one cycle after each start. This shows that the latched configuration, not the live pins, decides the mode and the timing. Each frequency row runs both inputs at different rates, so counting the wrong input gives a wrong count.

// File: rtl/gcnt_pkg.sv
`timescale 1ns/1ps
package gcnt_pkg;

  typedef enum logic [2:0] {
    GC_IDLE,
    GC_SETTLE,
    GC_ARM,
    GC_MEASURE,
    GC_HOLD
  } gc_state_e;

  localparam int TICK_W = 7;

  function automatic logic [TICK_W-1:0] settle_ticks(input logic [1:0] gate, input logic keep);
    if (keep)         return TICK_W'(2);
    else if (gate[1]) return TICK_W'(8);
    else              return TICK_W'(4);
  endfunction

  function automatic logic [TICK_W-1:0] window_ticks(input logic [1:0] gate);
    case (gate)
      2'b00:   return TICK_W'(4);
      2'b01:   return TICK_W'(8);
      2'b10:   return TICK_W'(32);
      default: return TICK_W'(64);
    endcase
  endfunction

  function automatic logic [1:0] period_span(input logic [1:0] gate);
    return gate[1] ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/gcnt_sync.sv
`timescale 1ns/1ps
module gcnt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] shreg;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      last_q <= 1'b0;
    end else begin
      shreg  <= {shreg[STAGES-2:0], d_i};
      last_q <= shreg[STAGES-1];
    end
  end

  assign rise_o = shreg[STAGES-1] & ~last_q;

  // R3: a rising edge needs a low sample first, so two detections never sit in adjacent cycles
  p_rise_isolated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);
endmodule

// File: rtl/gcnt_ticker.sv
`timescale 1ns/1ps
module gcnt_ticker #(
  parameter int TW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic [TW-1:0] limit_i,
  output logic          hit_o
);
  logic [TW-1:0] cnt_q;

  assign hit_o = tick_i && (cnt_q == limit_i - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr_i || hit_o) cnt_q <= '0;
    else if (tick_i)         cnt_q <= cnt_q + 1'b1;
  end

  // R5: the tick count never runs past the active limit
  p_tick_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    cnt_q < limit_i);
endmodule

// File: rtl/gcnt_accum.sv
`timescale 1ns/1ps
module gcnt_accum #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] value_o
);
  localparam logic [W-1:0] MAXV = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         value_o <= '0;
    else if (clr_i)                     value_o <= '0;
    else if (inc_i && value_o != MAXV)  value_o <= value_o + 1'b1;
  end

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (value_o == MAXV && !clr_i) |=> value_o == MAXV);
endmodule

// File: rtl/gcnt_top.sv
`timescale 1ns/1ps
module gcnt_top
  import gcnt_pkg::*;
#(
  parameter int COUNT_W     = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ms_tick_i,
  input  logic               start_i,
  input  logic [1:0]         src_mode_i,
  input  logic [1:0]         gate_sel_i,
  input  logic               bias_keep_i,
  input  logic               hi_in_i,
  input  logic               lo_in_i,
  output logic [COUNT_W-1:0] count_o,
  output logic               done_o,
  output logic               pulldown_en_o
);
  localparam int NSRC = 2;

  gc_state_e         state_q, state_d;
  logic [1:0]        mode_q, gate_q;
  logic              keep_q;
  logic [NSRC-1:0]   raw_in, rise;
  logic              freq_mode, edge_sel;
  logic [1:0]        span_q;
  logic              tick_en, tick_clr, tick_hit;
  logic [TICK_W-1:0] tick_limit;
  logic              acc_inc, acc_clr, last_period;

  assign raw_in = {hi_in_i, lo_in_i};

  for (genvar g = 0; g < NSRC; g++) begin : g_sync
    gcnt_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(raw_in[g]), .rise_o(rise[g])
    );
  end

  assign freq_mode = (mode_q != 2'b00);
  assign edge_sel  = mode_q[1] ? rise[1] : rise[0];

  // configuration is captured as start rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 2'b00;
      gate_q <= 2'b00;
      keep_q <= 1'b0;
    end else if (state_q == GC_IDLE && start_i) begin
      mode_q <= src_mode_i;
      gate_q <= gate_sel_i;
      keep_q <= bias_keep_i;
    end
  end

  assign tick_limit = (state_q == GC_SETTLE) ? settle_ticks(gate_q, keep_q) : window_ticks(gate_q);
  assign tick_en    = ms_tick_i && ((state_q == GC_SETTLE) || (state_q == GC_MEASURE && freq_mode));
  assign tick_clr   = !((state_q == GC_SETTLE) || (state_q == GC_MEASURE));

  gcnt_ticker #(.TW(TICK_W)) u_ticker (
    .clk(clk), .rst_n(rst_n), .clr_i(tick_clr), .tick_i(tick_en),
    .limit_i(tick_limit), .hit_o(tick_hit)
  );

  // rising edges seen so far inside a period window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   span_q <= '0;
    else if (state_q != GC_MEASURE)               span_q <= '0;
    else if (edge_sel)                            span_q <= span_q + 1'b1;
  end

  assign last_period = edge_sel && (span_q == period_span(gate_q) - 1'b1);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GC_IDLE:    if (start_i) state_d = GC_SETTLE;
      GC_SETTLE:  if (tick_hit) state_d = freq_mode ? GC_MEASURE : GC_ARM;
      GC_ARM:     if (edge_sel) state_d = GC_MEASURE;
      GC_MEASURE: if (freq_mode ? tick_hit : last_period) state_d = GC_HOLD;
      GC_HOLD:    state_d = GC_HOLD;
      default:    state_d = GC_IDLE;
    endcase
    if (!start_i) state_d = GC_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GC_IDLE;
    else        state_q <= state_d;
  end

  assign acc_clr = !start_i || (state_q == GC_IDLE);
  assign acc_inc = (state_q == GC_MEASURE) && (freq_mode ? edge_sel : 1'b1);

  gcnt_accum #(.W(COUNT_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .clr_i(acc_clr), .inc_i(acc_inc), .value_o(count_o)
  );

  assign done_o        = (state_q == GC_HOLD);
  assign pulldown_en_o = (state_q == GC_IDLE) && !bias_keep_i;

  p_idle_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> (count_o == '0 && !done_o));

  p_hold_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i) |=> (done_o && $stable(count_o)));

  p_pulldown_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulldown_en_o |-> (count_o == '0 && !done_o));

  p_cfg_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != GC_IDLE && start_i) |=> ($stable(mode_q) && $stable(gate_q) && $stable(keep_q)));
endmodule

// File: tb/gcnt_top_tb.sv
`timescale 1ns/1ps
module gcnt_top_tb_top;
  localparam int TICK_CYC = 20;

  typedef struct packed {
    logic [1:0]  sel;
    logic [1:0]  gate;
    logic        keep;
    logic [7:0]  hi_half;
    logic [7:0]  lo_half;
    logic [19:0] expv;
    logic [7:0]  tks;   // settle + gate ticks, 0 = no timing check
  } vec_t;

  // R2 R3 R4 R5 R10: the source code picks the input, each row runs both inputs
  localparam vec_t VECS [8] = '{
    '{2'b10, 2'b00, 1'b0, 8'd4, 8'd25, 20'd10,  8'd8},
    '{2'b11, 2'b01, 1'b1, 8'd4, 8'd25, 20'd20,  8'd10},
    '{2'b01, 2'b10, 1'b0, 8'd4, 8'd10, 20'd32,  8'd40},
    '{2'b01, 2'b11, 1'b1, 8'd4, 8'd10, 20'd64,  8'd66},
    '{2'b00, 2'b00, 1'b0, 8'd4, 8'd25, 20'd50,  8'd0},
    '{2'b00, 2'b01, 1'b1, 8'd4, 8'd25, 20'd50,  8'd0},
    '{2'b00, 2'b10, 1'b0, 8'd4, 8'd25, 20'd100, 8'd0},
    '{2'b00, 2'b11, 1'b1, 8'd3, 8'd30, 20'd120, 8'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0, ms_tick = 1'b0, start = 1'b0;
  logic [1:0] src = 2'b00, gate = 2'b00;
  logic keep = 1'b0, hi_in = 1'b0, lo_in = 1'b0;
  logic [19:0] count;
  logic [7:0]  count_sat;
  logic done, done_sat, pd_en, pd_sat;
  int hi_half = 4, lo_half = 25, tc = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  gcnt_top dut_i (
    .clk(clk), .rst_n(rst_n), .ms_tick_i(ms_tick), .start_i(start),
    .src_mode_i(src), .gate_sel_i(gate), .bias_keep_i(keep),
    .hi_in_i(hi_in), .lo_in_i(lo_in),
    .count_o(count), .done_o(done), .pulldown_en_o(pd_en)
  );

  gcnt_top #(.COUNT_W(8)) dut_sat_i (
    .clk(clk), .rst_n(rst_n), .ms_tick_i(ms_tick), .start_i(start),
    .src_mode_i(src), .gate_sel_i(gate), .bias_keep_i(keep),
    .hi_in_i(hi_in), .lo_in_i(lo_in),
    .count_o(count_sat), .done_o(done_sat), .pulldown_en_o(pd_sat)
  );

  always @(negedge clk) begin
    if (tc == TICK_CYC - 1) begin tc = 0; ms_tick = 1'b1; end
    else begin tc = tc + 1; ms_tick = 1'b0; end
  end

  always begin repeat (hi_half) @(negedge clk); hi_in = ~hi_in; end
  always begin repeat (lo_half) @(negedge clk); lo_in = ~lo_in; end

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_done(inout int n);
    while (!done && n < 6000) begin @(negedge clk); n++; end
    if (!done) chk("R7 timeout", 1'b0, 0, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 1'b0, 0, 1);
    finish_run();
  end

  initial begin
    int n;
    logic [19:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 and R6 reset state
    chk("R1 reset count", count == 0, count, 0);
    chk("R1 reset done", done == 0, done, 0);
    chk("R6 pulldown idle keep=0", pd_en == 1, pd_en, 1);
    keep = 1'b1;
    @(negedge clk);
    chk("R6 pulldown idle keep=1", pd_en == 0, pd_en, 0);

    foreach (VECS[i]) begin
      vec_t v;
      v = VECS[i];
      hi_half = int'(v.hi_half);
      lo_half = int'(v.lo_half);
      src = v.sel; gate = v.gate; keep = v.keep;
      repeat (500) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      // R9: scramble the configuration once it has been captured
      src = ~v.sel; gate = ~v.gate; keep = ~v.keep;
      n = 1;
      wait_done(n);
      if (v.sel != 2'b00)
        chk($sformatf("R3 R9 R10 row %0d freq count", i), count == v.expv, count, v.expv);
      else
        chk($sformatf("R4 R9 row %0d period count", i), count == v.expv, count, v.expv);
      if (v.tks != 0)
        chk($sformatf("R5 row %0d cycles to done", i),
            n > (int'(v.tks) - 1) * TICK_CYC && n <= int'(v.tks) * TICK_CYC + 3,
            n, int'(v.tks) * TICK_CYC);
      held = count;
      repeat (50) @(negedge clk);
      chk($sformatf("R7 row %0d done held", i), done == 1, done, 1);
      chk($sformatf("R7 row %0d count frozen", i), count == held, count, held);
      start = 1'b0;
      @(negedge clk);
      chk($sformatf("R1 row %0d clear count", i), count == 0, count, 0);
      chk($sformatf("R1 row %0d clear done", i), done == 0, done, 0);
    end

    // R1 and R6: abort in the middle of a long gate
    hi_half = 4; src = 2'b10; gate = 2'b11; keep = 1'b0;
    repeat (100) @(negedge clk);
    start = 1'b1;
    repeat (300) @(negedge clk);
    chk("R6 no pulldown while measuring", pd_en == 0, pd_en, 0);
    chk("R3 mid-gate count nonzero", count != 0, count, 1);
    start = 1'b0;
    @(negedge clk);
    chk("R1 abort clears count", count == 0, count, 0);
    chk("R1 abort clears done", done == 0, done, 0);
    chk("R6 pulldown back after abort", pd_en == 1, pd_en, 1);

    // R8: 400-cycle period, exact at full width and clamped at 8 bits
    lo_half = 200; src = 2'b00; gate = 2'b00; keep = 1'b1;
    repeat (1000) @(negedge clk);
    start = 1'b1;
    n = 0;
    wait_done(n);
    @(negedge clk);
    chk("R4 long period full width", count == 400, count, 400);
    chk("R8 saturated done", done_sat == 1, done_sat, 1);
    chk("R8 saturated count", count_sat == 8'hFF, count_sat, 255);
    start = 1'b0;
    @(negedge clk);
    chk("R1 saturated instance cleared", count_sat == 0, count_sat, 0);

    finish_run();
  end
endmodule